// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small processor core built around one 16-bit accumulator. It runs a reduced instruction set from a synchronous, word-addressed, single-port memory. Each instruction is one 16-bit word. The top four bits hold the operation code and the low twelve bits hold either a memory address or a register operation pattern. The core implements five operations: load the accumulator from memory, store the accumulator to memory, skip the next instruction when the accumulator is non-negative, complement the accumulator, and halt. Every other word runs as a no-operation.

Software places a program in memory and drives the entry address on `start_addr` while reset is held. The core begins fetching at that address once reset is released. The `halted` output reports that the machine has stopped, and `acc` shows the accumulator at all times so the result can be observed. The memory read port has one cycle of latency: data for an address presented in one cycle appears in the next.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, `acc` becomes 0, `halted` becomes 0 and the program counter loads `start_addr`. In the first cycle after release, `mem_addr` equals `start_addr` and `mem_wr` is 0.
- R2: A word of the form 0x2nnn (operation code 2 in bits 15:12) loads `acc` with the memory word at address nnn (bits 11:0).
- R3: A word of the form 0x3nnn writes `acc` to address nnn. The write strobe `mem_wr` is high for exactly one cycle, and the store leaves `acc` unchanged.
- R4: The word 0x7200 replaces `acc` with its bitwise complement.
- R5: The word 0x7010 skips the following instruction when `acc` bit 15 is 0, so the program counter advances by two. When bit 15 is 1, execution continues with the next word.
- R6: The word 0x7001 raises `halted`, which then stays high until reset. While halted, `mem_wr` stays 0, `mem_addr` stays constant and `acc` does not change.
- R7: Any word that is not one of 0x2nnn, 0x3nnn, 0x7200, 0x7010 or 0x7001 leaves `acc` and memory unchanged, and execution moves on to the next address.
- R8: Instructions run in address order. Each instruction takes two cycles: a fetch cycle followed by an execute cycle. A load takes one extra cycle. The program counter wraps at the top of the 12-bit address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_addr | input | 12 | Program entry address, loaded during reset |
| mem_addr | output | 12 | Memory word address for read and write |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Data written to memory |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |
| acc | output | 16 | Current accumulator value |

## Verification
The assertions assume that `mem_rdata` always returns, one cycle later, the word at the address the core presented, and that reset is held for at least two edges, so the history seen just after release is already the reset state. They also assume that no program runs into uninitialised memory. The bench meets these assumptions with a behavioural memory of one-cycle latency and a two-cycle reset. Its random programs store only into a separate data region and end with two halt words, so a skip on the last instruction still lands on a halt.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam logic [3:0] OP_LDA = 4'h2;
   localparam logic [3:0] OP_STA = 4'h3;
   localparam logic [3:0] OP_REG = 4'h7;
   localparam int BIT_CMA = 9;
   localparam int BIT_SPA = 4;
   localparam int BIT_HLT = 0;

   typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_LOAD, ST_HALT} acc_state_e;
   typedef enum logic [2:0] {K_NOP, K_LDA, K_STA, K_CMA, K_SPA, K_HLT} acc_kind_e;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0]   word,
   output acc_kind_e       kind,
   output logic [DW-5:0]   addr
);
   localparam int AW = DW - 4;
   localparam logic [AW-1:0] PAT_CMA = AW'(1) << BIT_CMA;
   localparam logic [AW-1:0] PAT_SPA = AW'(1) << BIT_SPA;
   localparam logic [AW-1:0] PAT_HLT = AW'(1) << BIT_HLT;

   always_comb begin
      addr = word[AW-1:0];
      kind = K_NOP;
      case (word[DW-1:DW-4])
         OP_LDA: kind = K_LDA;
         OP_STA: kind = K_STA;
         OP_REG: begin
            if (addr == PAT_CMA)      kind = K_CMA;
            else if (addr == PAT_SPA) kind = K_SPA;
            else if (addr == PAT_HLT) kind = K_HLT;
         end
         default: kind = K_NOP;
      endcase
   end
endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] start,
   input  logic          inc,
   input  logic          skip,
   output logic [AW-1:0] pc
);
   logic [AW-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc_q <= start;
      else
         pc_q <= pc_q + AW'(inc) + AW'(skip);
   end

   assign pc = pc_q;
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  acc_kind_e  kind,
   input  logic       sign,
   output acc_state_e state,
   output logic       pc_inc,
   output logic       pc_skip,
   output logic       acc_ld,
   output logic       acc_cm,
   output logic       wr,
   output logic       halted
);
   acc_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_FETCH: st_d = ST_EXEC;
         ST_EXEC: begin
            if (kind == K_LDA)      st_d = ST_LOAD;
            else if (kind == K_HLT) st_d = ST_HALT;
            else                    st_d = ST_FETCH;
         end
         ST_LOAD: st_d = ST_FETCH;
         default: st_d = ST_HALT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_FETCH;
      else        st_q <= st_d;
   end

   assign state   = st_q;
   assign pc_inc  = (st_q == ST_EXEC);
   assign pc_skip = (st_q == ST_EXEC) && (kind == K_SPA) && !sign;
   assign acc_ld  = (st_q == ST_LOAD);
   assign acc_cm  = (st_q == ST_EXEC) && (kind == K_CMA);
   assign wr      = (st_q == ST_EXEC) && (kind == K_STA);
   assign halted  = (st_q == ST_HALT);
endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-5:0] start_addr,
   output logic [DW-5:0] mem_addr,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          halted,
   output logic [DW-1:0] acc
);
   localparam int AW = DW - 4;

   if (DW < 16) begin : g_dw_check
      $error("acc_core: DW must be at least 16");
   end

   acc_kind_e     kind;
   acc_state_e    state_q;
   logic [AW-1:0] op_addr;
   logic [AW-1:0] pc;
   logic          pc_inc, pc_skip, acc_ld, acc_cm;
   logic [DW-1:0] acc_q;

   acc_decode #(.DW(DW)) u_dec (
      .word (mem_rdata),
      .kind (kind),
      .addr (op_addr)
   );

   acc_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .kind    (kind),
      .sign    (acc_q[DW-1]),
      .state   (state_q),
      .pc_inc  (pc_inc),
      .pc_skip (pc_skip),
      .acc_ld  (acc_ld),
      .acc_cm  (acc_cm),
      .wr      (mem_wr),
      .halted  (halted)
   );

   acc_pc #(.AW(AW)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_addr),
      .inc   (pc_inc),
      .skip  (pc_skip),
      .pc    (pc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= '0;
      else if (acc_ld) acc_q <= mem_rdata;
      else if (acc_cm) acc_q <= ~acc_q;
   end

   assign mem_addr  = (state_q == ST_EXEC) ? op_addr : pc;
   assign mem_wdata = acc_q;
   assign acc       = acc_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
   import acc_pkg::*;
#(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          halted,
   input logic          mem_wr,
   input logic [DW-5:0] mem_addr,
   input logic [DW-1:0] acc,
   input acc_state_e    st
);
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R6
   AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_wr); // R6
   AST_HALT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(mem_addr)); // R6
   AST_HALT_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(acc)); // R6
   AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr); // R3
   AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> $stable(acc)); // R3
   AST_ACC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc) |-> ($past(st) == ST_LOAD || $past(st) == ST_EXEC)); // R7
endmodule

bind acc_core acc_core_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .halted   (halted),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr),
   .acc      (acc),
   .st       (state_q)
);

// File: tb/tb_acc_core.sv
module tb_acc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] start_addr = 12'h100;
   logic [11:0] mem_addr;
   logic        mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        halted;
   logic [15:0] acc;

   logic [15:0] mem     [4096];
   logic [15:0] ref_mem [4096];
   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   acc_core dut (
      .clk, .rst_n, .start_addr, .mem_addr, .mem_wr,
      .mem_wdata, .mem_rdata, .halted, .acc
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_run(input logic [11:0] start, output logic [15:0] a,
                            output int cyc);
      logic [11:0] pc;
      logic [15:0] w;
      pc = start; a = '0; cyc = 0;
      for (int k = 0; k < 2000; k++) begin
         w = ref_mem[pc];
         pc = pc + 12'd1;
         cyc += 2;
         if (w[15:12] == 4'h2) begin
            a = ref_mem[w[11:0]];
            cyc += 1;
         end else if (w[15:12] == 4'h3) begin
            ref_mem[w[11:0]] = a;
         end else if (w == 16'h7200) begin
            a = ~a;
         end else if (w == 16'h7010) begin
            if (!a[15]) pc = pc + 12'd1;
         end else if (w == 16'h7001) begin
            break;
         end
      end
   endtask

   task automatic do_reset(input logic [11:0] start);
      @(negedge clk);
      rst_n = 1'b0;
      start_addr = start;
      repeat (2) @(negedge clk);
   endtask

   task automatic run_check(input logic [11:0] start, input string tag);
      logic [15:0] exp_acc, hold_acc;
      logic [11:0] hold_addr;
      int exp_cyc, cyc, bad;
      for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
      model_run(start, exp_acc, exp_cyc);
      do_reset(start);
      chk(acc == 16'h0 && !halted, "R1", {tag, " reset state"}, {15'd0, halted, acc}, 32'h0);
      rst_n = 1'b1;
      chk(mem_addr == start && !mem_wr, "R1", {tag, " first fetch address"}, {19'd0, mem_wr, mem_addr}, {20'd0, start});
      cyc = 0;
      while (!halted && cyc < 5000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      chk(cyc == exp_cyc, "R8", {tag, " cycles to halt"}, cyc, exp_cyc);
      chk(acc == exp_acc, "R2", {tag, " final accumulator"}, {16'd0, acc}, {16'd0, exp_acc});
      bad = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk(bad == 0, "R3", {tag, " memory words differing"}, bad, 0);
      hold_acc = acc; hold_addr = mem_addr; bad = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!halted || mem_wr || mem_addr != hold_addr || acc != hold_acc) bad++;
      end
      chk(bad == 0, "R6", {tag, " halt holds"}, bad, 0);
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected halt");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [11:0] st;
      int n;
      void'($urandom(32'd20240611));
      repeat (2) @(negedge clk);

      // R2 R3 R5 R4: classic sequence, positive operand -> complement skipped
      clear_mem();
      mem[12'h100] = 16'h2105; mem[12'h101] = 16'h7010; mem[12'h102] = 16'h7200;
      mem[12'h103] = 16'h3106; mem[12'h104] = 16'h7001; mem[12'h105] = 16'h0A3C;
      run_check(12'h100, "seq_pos");
      chk(acc == 16'h0A3C, "R5", "skip on non-negative", {16'd0, acc}, 32'h0A3C);
      chk(mem[12'h106] == 16'h0A3C, "R3", "stored word", {16'd0, mem[12'h106]}, 32'h0A3C);

      // R4 R5: negative operand -> no skip, complement runs
      clear_mem();
      mem[12'h100] = 16'h2105; mem[12'h101] = 16'h7010; mem[12'h102] = 16'h7200;
      mem[12'h103] = 16'h3106; mem[12'h104] = 16'h7001; mem[12'h105] = 16'hCAB4;
      run_check(12'h100, "seq_neg");
      chk(acc == 16'h354B, "R4", "complement result", {16'd0, acc}, 32'h354B);
      chk(mem[12'h106] == 16'h354B, "R3", "stored complement", {16'd0, mem[12'h106]}, 32'h354B);

      // R7: unimplemented words leave acc alone and advance by one
      clear_mem();
      mem[12'h200] = 16'h2300; mem[12'h201] = 16'h0123; mem[12'h202] = 16'h7002;
      mem[12'h203] = 16'hF00F; mem[12'h204] = 16'h7210; mem[12'h205] = 16'h5000;
      mem[12'h206] = 16'h7001; mem[12'h300] = 16'h8421;
      run_check(12'h200, "nop");
      chk(acc == 16'h8421, "R7", "acc after no-ops", {16'd0, acc}, 32'h8421);

      // R8: program counter wraps from FFF to 000
      clear_mem();
      mem[12'hFFE] = 16'h2010; mem[12'hFFF] = 16'h7200; mem[12'h000] = 16'h7001;
      mem[12'h010] = 16'h00FF;
      run_check(12'hFFE, "wrap");
      chk(acc == 16'hFF00, "R8", "wrap result", {16'd0, acc}, 32'hFF00);

      // R6: halt as the very first word
      clear_mem();
      mem[12'h050] = 16'h7001;
      run_check(12'h050, "halt_first");

      // random programs
      for (int p = 0; p < 30; p++) begin
         clear_mem();
         for (int i = 0; i < 32; i++) mem[12'h800 + i] = 16'($urandom);
         st = 12'($urandom % 12'h700);
         n = 5 + int'($urandom % 30);
         for (int i = 0; i < n; i++) begin
            case ($urandom % 7)
               0, 1: v = 16'h2800 | 16'($urandom % 32);
               2:    v = 16'h3800 | 16'($urandom % 32);
               3:    v = 16'h7200;
               4:    v = 16'h7010;
               5:    v = 16'h7000 | (16'h1 << (1 + $urandom % 3));
               default: v = 16'h4000 | 16'($urandom % 16'h1000);
            endcase
            mem[st + 12'(i)] = v;
         end
         mem[st + 12'(n)]     = 16'h7001;
         mem[st + 12'(n + 1)] = 16'h7001;
         run_check(st, "random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule